// File: doc/BRIEF.md
# External Memory Strobe Sequencer

This block turns the oscillator clock of an 8051-class core into the strobes and address bytes of the external memory bus. It divides the clock into machine cycles of twelve oscillator periods, split into two halves of six. Each half can carry an address-latch pulse followed by a code-read strobe. The core presents a description of the coming machine cycle: whether code is executed from external memory, whether an external data transfer takes place and with which pointer width, whether a table-read instruction runs, the state of the latch-pulse disable bit, and the port-2 latch value. The block samples these once per machine cycle, when the cycle starts.

When the cycle is a data transfer, the second latch pulse and both code-read strobes are dropped. Port 2 then carries either the high byte of the wide pointer or the frozen port-2 latch. When the disable bit is set and code runs from internal memory, the latch output is released to a weak-high level. It stays released except in cycles that carry a table read or a data transfer. The read and write data strobes are not produced here. Port 0 is only shown as an address driver with an enable.

Top module: `xbus_strobe_gen`

## Requirements
- R1: While `rst_n` is low, and in the clock after it is sampled low, outputs are `ale`=0, `ale_drv`=1, `psen_n`=1, `p0_oe`=0, `p0_out`=0, `p2_out`=8'hFF.
- R2: A machine cycle is 12 clocks, with phases 0..11 counted from the first clock after reset release. In a non-data cycle with the latch enabled, `ale` is 1 exactly in phases 0, 1, 6 and 7, which gives two pulses per machine cycle.
- R3: In a data-transfer cycle (`xdata_req`=1 at cycle start), `ale` is 1 only in phases 0 and 1. The second pulse is skipped.
- R4: `psen_n` is 0 exactly in phases 3-5 and 9-11 of a cycle with `code_ext`=1 and `xdata_req`=0. It stays 1 in every data-transfer cycle and whenever `code_ext`=0.
- R5: With `ale_off`=1, `code_ext`=0, `movc_cyc`=0 and `xdata_req`=0 at cycle start, `ale_drv` is 0 and `ale` reads 1 for the whole cycle.
- R6: `ale_off` has no effect when `code_ext`, `movc_cyc` or `xdata_req` is 1 at cycle start. In that case `ale` pulses as in R2 or R3 with `ale_drv`=1.
- R7: `p0_oe` is 1 in phases 0-2 of external-fetch and data-transfer cycles, and also in phases 6-8 of external-fetch cycles. In those phases `p0_out` carries bits 7:0 of the address in use, and it is 0 otherwise. The outputs are floated in every phase where `psen_n` is 0.
- R8: `p2_out` shows bits 15:8 of the fetch address in external-fetch cycles. It shows bits 15:8 of `data_addr` in data-transfer cycles with `xdata_wide`=1.
- R9: In a data-transfer cycle with `xdata_wide`=0, and in internal-execution cycles, `p2_out` equals `p2_sfr` as sampled at cycle start. It does not change for the rest of the cycle, even when `p2_sfr` changes.
- R10: The cycle controls and `data_addr` are sampled only on the clock that enters phase 0. `code_addr` is sampled there, and again on the clock that enters phase 6 of a non-data cycle for the second fetch of the cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Synchronous active-low reset |
| code_ext | input | 1 | Code is executed from external memory |
| xdata_req | input | 1 | Coming cycle is an external data transfer |
| xdata_wide | input | 1 | Data transfer uses a 16-bit pointer |
| movc_cyc | input | 1 | Coming cycle executes a table read |
| ale_off | input | 1 | Latch-pulse disable bit |
| p2_sfr | input | 8 | Port-2 latch contents |
| code_addr | input | 16 | Fetch address |
| data_addr | input | 16 | Data-transfer address |
| ale | output | 1 | Address-latch pulse (reads 1 when released) |
| ale_drv | output | 1 | Latch pin actively driven |
| psen_n | output | 1 | Code-read strobe, active low |
| p0_out | output | 8 | Port-0 low address byte |
| p0_oe | output | 1 | Port-0 output enable |
| p2_out | output | 8 | Port-2 high address byte or latch value |

## Verification
On every cycle, the assertions check several rules. The phase stays in range, and a latch pulse only rises at the start of a half. No pulse appears past phase 1 of a data transfer. The code-read strobe never overlaps the latch pulse or a driven port 0, and the captured port-2 value holds between cycle starts. Other behaviours only show up in the bench's scenarios: the exact phases of each strobe, pulse counts per machine cycle, the priority of fetch and transfer over the disable bit, and the choice of port-2 source. The bench also exercises the second-half address reload, including a wrap from FFFF to 0000. It shows that a port-2 latch change mid-cycle is ignored.

// File: rtl/xbus_pkg.sv
// Shared types for the external bus strobe sequencer.
// Assumes an 8-bit port-2 latch and a 16-bit external address.
package xbus_pkg;
    localparam int BYTE_W = 8;

    // Descriptor of one machine cycle, captured at its start.
    typedef struct packed {
        logic              code_ext;
        logic              data;
        logic              wide;
        logic              ale_en;
        logic [BYTE_W-1:0] p2;
    } cyc_desc_t;

    localparam cyc_desc_t CYC_RESET = '{code_ext: 1'b0, data: 1'b0, wide: 1'b0,
                                        ale_en: 1'b1, p2: {BYTE_W{1'b1}}};
endpackage

// File: rtl/xbus_phase_ctr.sv
// Machine-cycle phase counter. Counts 0..CYCLE_CLKS-1 and flags the
// clocks that enter phase 0 and the second half. Reset parks it on the
// last phase so the first clock after release starts a fresh cycle.
module xbus_phase_ctr #(
    parameter int CYCLE_CLKS = 12,
    parameter int PH_W       = $clog2(CYCLE_CLKS)
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic [PH_W-1:0] phase,
    output logic            cyc_start,
    output logic            half_start
);
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(CYCLE_CLKS - 1);
    localparam logic [PH_W-1:0] PH_MID  = PH_W'(CYCLE_CLKS / 2 - 1);

    // Advance the phase, wrapping at the end of a machine cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)                phase <= PH_LAST;
        else if (phase == PH_LAST) phase <= '0;
        else                       phase <= phase + 1'b1;
    end

    // Load strobes for the next clock edge.
    always_comb begin
        cyc_start  = (phase == PH_LAST);
        half_start = (phase == PH_MID);
    end

    assert_phase_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        phase <= PH_LAST);
    assert_phase_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_LAST) |=> (phase == '0));
endmodule

// File: rtl/xbus_cycle_latch.sv
// Captures the machine-cycle descriptor and the bus address. Controls
// and the data address are taken at cycle start; a non-data cycle also
// reloads the fetch address at the half point for its second fetch.
module xbus_cycle_latch #(
    parameter int ADDR_W = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cyc_start,
    input  logic                  half_start,
    input  logic                  code_ext,
    input  logic                  xdata_req,
    input  logic                  xdata_wide,
    input  logic                  movc_cyc,
    input  logic                  ale_off,
    input  logic [xbus_pkg::BYTE_W-1:0] p2_sfr,
    input  logic [ADDR_W-1:0]     code_addr,
    input  logic [ADDR_W-1:0]     data_addr,
    output xbus_pkg::cyc_desc_t   cyc,
    output logic [ADDR_W-1:0]     bus_addr
);
    import xbus_pkg::*;

    // Descriptor register, loaded once per machine cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cyc <= CYC_RESET;
        end else if (cyc_start) begin
            cyc.code_ext <= code_ext;
            cyc.data     <= xdata_req;
            cyc.wide     <= xdata_wide;
            cyc.ale_en   <= !ale_off || code_ext || xdata_req || movc_cyc;
            cyc.p2       <= p2_sfr;
        end
    end

    // Address register: cycle-start select, half-point fetch reload.
    always_ff @(posedge clk) begin
        if (!rst_n)                     bus_addr <= '0;
        else if (cyc_start)             bus_addr <= xdata_req ? data_addr : code_addr;
        else if (half_start && !cyc.data) bus_addr <= code_addr;
    end

    assert_p2_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !cyc_start |=> $stable(cyc.p2));
    assert_desc_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !cyc_start |=> $stable(cyc.data) && $stable(cyc.ale_en));
endmodule

// File: rtl/xbus_strobe_decode.sv
// Decodes phase and cycle descriptor into pin values. Each half of a
// machine cycle has a latch-pulse window, an address-hold window one
// clock longer, and a code-read window at its end.
module xbus_strobe_decode #(
    parameter int CYCLE_CLKS = 12,
    parameter int ALE_W      = 2,
    parameter int PSEN_W     = 3,
    parameter int ADDR_W     = 16,
    parameter int PH_W       = $clog2(CYCLE_CLKS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [PH_W-1:0]       phase,
    input  xbus_pkg::cyc_desc_t   cyc,
    input  logic [ADDR_W-1:0]     bus_addr,
    output logic                  ale,
    output logic                  ale_drv,
    output logic                  psen_n,
    output logic [xbus_pkg::BYTE_W-1:0] p0_out,
    output logic                  p0_oe,
    output logic [xbus_pkg::BYTE_W-1:0] p2_out
);
    import xbus_pkg::*;

    localparam logic [PH_W-1:0] HALF_P   = PH_W'(CYCLE_CLKS / 2);
    localparam logic [PH_W-1:0] ALE_P    = PH_W'(ALE_W);
    localparam logic [PH_W-1:0] PSEN_S_P = PH_W'(CYCLE_CLKS / 2 - PSEN_W);

    logic            in_first;
    logic [PH_W-1:0] off;
    logic            fetch_ext;

    // Position within the current half and fetch classification.
    always_comb begin
        in_first  = (phase < HALF_P);
        off       = in_first ? phase : phase - HALF_P;
        fetch_ext = cyc.code_ext && !cyc.data;
    end

    // Latch pulse: second half dropped in data cycles, released if disabled.
    always_comb begin
        ale_drv = cyc.ale_en;
        ale     = cyc.ale_en ? ((off < ALE_P) && (!cyc.data || in_first)) : 1'b1;
    end

    // Code-read strobe at the end of each half of an external fetch cycle.
    always_comb psen_n = !(fetch_ext && (off >= PSEN_S_P));

    // Port 0 address byte across the latch fall, floated for the read.
    always_comb begin
        p0_oe  = (off <= ALE_P) && (fetch_ext || (cyc.data && in_first));
        p0_out = p0_oe ? bus_addr[BYTE_W-1:0] : '0;
    end

    // Port 2: high address byte, or the frozen latch value.
    always_comb
        p2_out = (fetch_ext || (cyc.data && cyc.wide)) ? bus_addr[ADDR_W-1:ADDR_W-BYTE_W]
                                                       : cyc.p2;

    assert_ale_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(ale) && ale_drv && $past(ale_drv)) |-> (phase == '0 || phase == HALF_P));
    assert_no_second_ale_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc.data && phase >= ALE_P) |-> !ale);
    assert_psen_ale_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !psen_n |-> (!ale && ale_drv));
endmodule

// File: rtl/xbus_strobe_gen.sv
// External memory strobe sequencer top. Ties the phase counter, the
// cycle latch and the pin decoder together. Assumes the core holds its
// cycle description valid on the clock that enters phase 0.
module xbus_strobe_gen #(
    parameter int CYCLE_CLKS = 12,
    parameter int ALE_W      = 2,
    parameter int PSEN_W     = 3,
    parameter int ADDR_W     = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              code_ext,
    input  logic              xdata_req,
    input  logic              xdata_wide,
    input  logic              movc_cyc,
    input  logic              ale_off,
    input  logic [7:0]        p2_sfr,
    input  logic [ADDR_W-1:0] code_addr,
    input  logic [ADDR_W-1:0] data_addr,
    output logic              ale,
    output logic              ale_drv,
    output logic              psen_n,
    output logic [7:0]        p0_out,
    output logic              p0_oe,
    output logic [7:0]        p2_out
);
    import xbus_pkg::*;

    localparam int PH_W = $clog2(CYCLE_CLKS);

    logic [PH_W-1:0]   phase;
    logic              cyc_start;
    logic              half_start;
    cyc_desc_t         cyc;
    logic [ADDR_W-1:0] bus_addr;

    xbus_phase_ctr #(.CYCLE_CLKS(CYCLE_CLKS), .PH_W(PH_W)) u_ctr (
        .clk(clk), .rst_n(rst_n), .phase(phase),
        .cyc_start(cyc_start), .half_start(half_start)
    );

    xbus_cycle_latch #(.ADDR_W(ADDR_W)) u_latch (
        .clk(clk), .rst_n(rst_n), .cyc_start(cyc_start), .half_start(half_start),
        .code_ext(code_ext), .xdata_req(xdata_req), .xdata_wide(xdata_wide),
        .movc_cyc(movc_cyc), .ale_off(ale_off), .p2_sfr(p2_sfr),
        .code_addr(code_addr), .data_addr(data_addr),
        .cyc(cyc), .bus_addr(bus_addr)
    );

    xbus_strobe_decode #(.CYCLE_CLKS(CYCLE_CLKS), .ALE_W(ALE_W), .PSEN_W(PSEN_W),
                         .ADDR_W(ADDR_W), .PH_W(PH_W)) u_dec (
        .clk(clk), .rst_n(rst_n), .phase(phase), .cyc(cyc), .bus_addr(bus_addr),
        .ale(ale), .ale_drv(ale_drv), .psen_n(psen_n),
        .p0_out(p0_out), .p0_oe(p0_oe), .p2_out(p2_out)
    );

    assert_p0_float_psen_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !psen_n |-> !p0_oe);
    assert_disabled_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !ale_drv |-> (psen_n && !p0_oe));
endmodule

// File: tb/tb_xbus_strobe_gen.sv
`timescale 1ns/1ps
module tb_xbus_strobe_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        code_ext = 0, xdata_req = 0, xdata_wide = 0, movc_cyc = 0, ale_off = 0;
    logic [7:0]  p2_sfr = 8'h00;
    logic [15:0] code_addr = '0, data_addr = '0;
    logic        ale, ale_drv, psen_n, p0_oe;
    logic [7:0]  p0_out, p2_out;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #2.5 clk = ~clk;

    xbus_strobe_gen dut (
        .clk(clk), .rst_n(rst_n), .code_ext(code_ext), .xdata_req(xdata_req),
        .xdata_wide(xdata_wide), .movc_cyc(movc_cyc), .ale_off(ale_off),
        .p2_sfr(p2_sfr), .code_addr(code_addr), .data_addr(data_addr),
        .ale(ale), .ale_drv(ale_drv), .psen_n(psen_n),
        .p0_out(p0_out), .p0_oe(p0_oe), .p2_out(p2_out)
    );

    // {code_ext, xdata_req, wide, movc, ale_off, p2[8], code_addr[16], data_addr[16]}
    localparam int NV = 9;
    localparam logic [44:0] VEC [NV] = '{
        {5'b00000, 8'hA5, 16'h0123, 16'h0000},  // internal execution
        {5'b10000, 8'h11, 16'h1234, 16'h0000},  // external fetch
        {5'b11100, 8'h3C, 16'h2000, 16'hBEEF},  // wide data transfer
        {5'b11000, 8'h5A, 16'h2001, 16'h00C7},  // narrow data transfer
        {5'b00001, 8'h66, 16'h0200, 16'h0000},  // latch disabled, internal
        {5'b10001, 8'h77, 16'h4F0E, 16'h0000},  // disable ignored, ext exec
        {5'b00011, 8'h88, 16'h0300, 16'h0000},  // disable overridden by table read
        {5'b01001, 8'h81, 16'h0301, 16'h0077},  // disable overridden by transfer
        {5'b10000, 8'h99, 16'hFFFF, 16'h0000}   // fetch address wrap
    };

    function automatic string tag_of(input logic [4:0] c);
        if (c[3])                 return c[0] ? "R6" : (c[2] ? "R8" : "R9");
        if (c[0])                 return (c[4] || c[1]) ? "R6" : "R5";
        if (c[4])                 return "R4";
        return "R2";
    endfunction

    task automatic check(input string tag, input logic [19:0] got, input logic [19:0] exp,
                         input int v, input int p);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s vec %0d phase %0d got %h exp %h", tag, v, p, got, exp);
        end
    endtask

    task automatic apply(input logic [44:0] e);
        {code_ext, xdata_req, xdata_wide, movc_cyc, ale_off} = e[44:40];
        p2_sfr    = e[39:32];
        code_addr = e[31:16];
        data_addr = e[15:0];
    endtask

    initial begin
        #(5.0 * 200000);
        n_fail++;
        $display("FAIL watchdog expired got running exp finished");
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        end
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", {ale, ale_drv, psen_n, p0_oe, p0_out, p2_out},
              {4'b0110, 8'h00, 8'hFF}, -1, -1);
        apply(VEC[0]);
        rst_n = 1'b1;
        for (int v = 0; v < NV; v++) begin
            logic [44:0] e;
            logic [4:0]  c;
            logic [15:0] ca2;
            logic        data, fext, en;
            int          ale_hi, psen_lo;
            e = VEC[v];
            c = e[44:40];
            ca2 = e[31:16] + 16'd1;
            data = c[3];
            fext = c[4] && !data;
            en = !c[0] || c[4] || c[3] || c[1];
            ale_hi = 0;
            psen_lo = 0;
            for (int p = 0; p < 12; p++) begin
                logic        h2, e_ale, e_ps, e_oe;
                logic [15:0] a;
                logic [7:0]  e_p0, e_p2;
                int          off;
                @(negedge clk);
                h2 = (p >= 6);
                off = p % 6;
                a = data ? e[15:0] : (h2 ? ca2 : e[31:16]);
                e_ale = en ? ((off < 2) && (!data || !h2)) : 1'b1;
                e_ps = !(fext && off >= 3);
                e_oe = (off <= 2) && (fext || (data && !h2));
                e_p0 = e_oe ? a[7:0] : 8'h00;
                e_p2 = (fext || (data && c[2])) ? a[15:8] : e[39:32];
                // R2 R3 R4 R7 R8 R9 R10 per-phase pin check
                check(tag_of(c), {ale, ale_drv, psen_n, p0_oe, p0_out, p2_out},
                      {e_ale, en, e_ps, e_oe, e_p0, e_p2}, v, p);
                if (ale && ale_drv) ale_hi++;
                if (!psen_n) psen_lo++;
                if (p == 5) begin
                    code_addr = ca2;         // R10: second-half fetch address
                    p2_sfr    = ~e[39:32];   // R9: mid-cycle change is ignored
                    data_addr = ~e[15:0];
                end
                if (p == 11 && v + 1 < NV) apply(VEC[v + 1]);
            end
            // R2 R3: pulse count per machine cycle; R4: strobe count
            check(data ? "R3" : "R2", 20'(ale_hi), 20'(!en ? 0 : (data ? 2 : 4)), v, 12);
            check("R4", 20'(psen_lo), 20'(fext ? 6 : 0), v, 12);
        end
        // R1: reset asserted mid-cycle returns to reset state
        apply(VEC[1]);
        repeat (4) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1", {ale, ale_drv, psen_n, p0_oe, p0_out, p2_out},
              {4'b0110, 8'h00, 8'hFF}, -2, -1);
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        end
        $finish;
    end
endmodule